// File: doc/BRIEF.md
# Pipeline Hazard Controller

This block watches the register specifiers of a five-stage in-order integer pipeline (fetch, decode, execute, memory, write-back) and decides three things every cycle. It steers each of the two execute-stage ALU operands to one of three sources: the register file, the result waiting in the memory stage, or the result being written back. It raises a stall when a load is followed directly by an instruction that reads the loaded register. It raises a flush when a branch resolved in decode is taken.

The controller keeps its own compact copy of the destination and source information for the execute, memory and write-back stages. The decode stage presents the fields of the instruction it holds, and these advance through the controller in step with the datapath. During a stall the controller puts a bubble into its execute-stage copy, with register-write and load controls cleared. The datapath holds the PC and the fetch/decode register, so decode presents the same instruction again in the next cycle. The register file writes in the first half of a cycle and reads in the second half. Because of this, a producer three instructions ahead needs no forwarding. Branches are predicted not taken, so a taken branch discards the one instruction fetched behind it.

Top module: `hazard_unit`

## Requirements
- R1: After reset the three stage copies are empty, so with idle decode inputs both selects read 0 and stall and flush are 0.
- R2: Operand select codes are 0 = register file, 1 = memory-stage result, 2 = write-back result. An execute-stage source that matches the memory-stage destination selects 1.
- R3: An execute-stage source that matches only the write-back destination selects 2.
- R4: When the memory-stage and write-back destinations both match the same source, the memory stage wins and the select is 1.
- R5: A producer three instructions ahead of the reader is not forwarded, and the select is 0.
- R6: Nothing is forwarded and no stall is raised for destination register 0, for a producer whose register-write control is low, or for a source whose use flag was low.
- R7: A load in execute whose destination matches a used source of the decode instruction raises stall for exactly one cycle. The next cycle carries a bubble in execute (selects 0, no stall), and when the dependent instruction reaches execute it takes the load data with select 2.
- R8: A load followed by an independent instruction causes no stall. A reader two instructions behind the load causes no stall and gets select 2.
- R9: A branch in decode with its taken flag high raises flush in that same cycle. An untaken branch raises no flush.
- R10: A taken branch that waits on a load-use stall raises no flush while stalled, and raises flush in the following cycle when it is presented again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_rs | input | RW | First source register of the decode instruction |
| dec_rt | input | RW | Second source register of the decode instruction |
| dec_use_rs | input | 1 | Decode instruction reads dec_rs |
| dec_use_rt | input | 1 | Decode instruction reads dec_rt |
| dec_rd | input | RW | Destination register of the decode instruction |
| dec_wen | input | 1 | Decode instruction writes a register |
| dec_load | input | 1 | Decode instruction is a load |
| dec_branch | input | 1 | Decode instruction is a conditional branch |
| dec_taken | input | 1 | Branch outcome resolved in decode |
| fwd_a | output | 2 | Source select for ALU operand A |
| fwd_b | output | 2 | Source select for ALU operand B |
| stall | output | 1 | Hold PC and fetch/decode register, insert bubble |
| flush | output | 1 | Clear the fetch/decode register |

## Verification
Stall and flush depend only on the current decode fields and the execute-stage copy, so they are due in the same cycle the decode instruction is presented. The selects describe the instruction that decode held one cycle earlier, so they are due one clock edge after it was presented. The bench drives each decode instruction just after a falling edge and samples one time unit later, before the next rising edge. Each select is checked while the following instruction is being presented, which matches the one-register lag without relying on the order of processes at a clock edge.

// File: rtl/hazard_unit.sv
module hazard_unit #(
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] dec_rs,
  input  logic [RW-1:0] dec_rt,
  input  logic          dec_use_rs,
  input  logic          dec_use_rt,
  input  logic [RW-1:0] dec_rd,
  input  logic          dec_wen,
  input  logic          dec_load,
  input  logic          dec_branch,
  input  logic          dec_taken,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          stall,
  output logic          flush
);
  localparam logic [1:0] SEL_RF  = 2'd0;
  localparam logic [1:0] SEL_MEM = 2'd1;
  localparam logic [1:0] SEL_WB  = 2'd2;
  localparam logic [RW-1:0] ZERO = '0;

  logic [RW-1:0] ex_rs, ex_rt, ex_rd, mem_rd, wb_rd;
  logic          ex_wen, ex_load, mem_wen, wb_wen;

  logic mem_live, wb_live, ex_ld_live;
  assign mem_live   = mem_wen && (mem_rd != ZERO);
  assign wb_live    = wb_wen && (wb_rd != ZERO);
  assign ex_ld_live = ex_load && ex_wen && (ex_rd != ZERO);

  assign fwd_a = (mem_live && ex_rs != ZERO && mem_rd == ex_rs) ? SEL_MEM :
                 (wb_live  && ex_rs != ZERO && wb_rd  == ex_rs) ? SEL_WB  : SEL_RF;
  assign fwd_b = (mem_live && ex_rt != ZERO && mem_rd == ex_rt) ? SEL_MEM :
                 (wb_live  && ex_rt != ZERO && wb_rd  == ex_rt) ? SEL_WB  : SEL_RF;

  assign stall = ex_ld_live &&
                 ((dec_use_rs && dec_rs == ex_rd) || (dec_use_rt && dec_rt == ex_rd));
  assign flush = dec_branch && dec_taken && !stall;

  always_ff @(posedge clk) begin
    if (!rst_n || stall) begin
      ex_rs   <= ZERO;
      ex_rt   <= ZERO;
      ex_rd   <= ZERO;
      ex_wen  <= 1'b0;
      ex_load <= 1'b0;
    end else begin
      ex_rs   <= dec_use_rs ? dec_rs : ZERO;
      ex_rt   <= dec_use_rt ? dec_rt : ZERO;
      ex_rd   <= dec_rd;
      ex_wen  <= dec_wen;
      ex_load <= dec_load;
    end
    if (!rst_n) begin
      mem_rd  <= ZERO;
      mem_wen <= 1'b0;
      wb_rd   <= ZERO;
      wb_wen  <= 1'b0;
    end else begin
      mem_rd  <= ex_rd;
      mem_wen <= ex_wen;
      wb_rd   <= mem_rd;
      wb_wen  <= mem_wen;
    end
  end

  assert_sel_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a != 2'd3) && (fwd_b != 2'd3));
  assert_wb_needs_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a == SEL_WB) |-> wb_wen);
  assert_no_r0_fwd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_b != SEL_RF) |-> (ex_rt != ZERO));
  assert_one_bubble_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);
  assert_bubble_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (!ex_wen && !ex_load));
  assert_flush_after_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(stall) && dec_branch && dec_taken) |-> flush);
endmodule

// File: tb/hazard_unit_bench.sv
module hazard_unit_bench;
  localparam int RW = 5;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [RW-1:0] dec_rs = '0, dec_rt = '0, dec_rd = '0;
  logic dec_use_rs = 0, dec_use_rt = 0, dec_wen = 0, dec_load = 0;
  logic dec_branch = 0, dec_taken = 0;
  logic [1:0] fwd_a, fwd_b;
  logic stall, flush;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hazard_unit #(.RW(RW)) u_hazard_unit (
    .clk(clk), .rst_n(rst_n), .dec_rs(dec_rs), .dec_rt(dec_rt),
    .dec_use_rs(dec_use_rs), .dec_use_rt(dec_use_rt), .dec_rd(dec_rd),
    .dec_wen(dec_wen), .dec_load(dec_load), .dec_branch(dec_branch),
    .dec_taken(dec_taken), .fwd_a(fwd_a), .fwd_b(fwd_b),
    .stall(stall), .flush(flush));

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic issue(input int rs, input bit urs, input int rt, input bit urt,
                       input int rd, input bit wen, input bit ld,
                       input bit br = 0, input bit tk = 0);
    @(negedge clk);
    dec_rs = RW'(rs); dec_use_rs = urs; dec_rt = RW'(rt); dec_use_rt = urt;
    dec_rd = RW'(rd); dec_wen = wen; dec_load = ld;
    dec_branch = br; dec_taken = tk;
    #1;
  endtask

  task automatic nop();
    issue(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic drain();
    repeat (4) nop();
  endtask

  task automatic t_reset();
    nop();
    chk("R1", "fwd_a", fwd_a, 0); chk("R1", "fwd_b", fwd_b, 0);
    chk("R1", "stall", stall, 0); chk("R1", "flush", flush, 0);
  endtask

  task automatic t_alu_chain();
    issue(1, 1, 2, 1, 3, 1, 0);
    issue(3, 1, 4, 1, 5, 1, 0);
    chk("R2", "stall alu", stall, 0);
    issue(5, 1, 3, 1, 6, 1, 0);
    chk("R2", "fwd_a dist1", fwd_a, 1); chk("R2", "fwd_b none", fwd_b, 0);
    issue(3, 1, 3, 1, 0, 1, 0);
    chk("R2", "fwd_a dist1 again", fwd_a, 1); chk("R3", "fwd_b dist2", fwd_b, 2);
    nop();
    chk("R5", "fwd_a dist3", fwd_a, 0); chk("R5", "fwd_b dist3", fwd_b, 0);
    drain();
  endtask

  task automatic t_priority();
    issue(0, 0, 0, 0, 7, 1, 0);
    issue(0, 0, 0, 0, 7, 1, 0);
    issue(7, 1, 7, 1, 8, 1, 0);
    nop();
    chk("R4", "fwd_a prio", fwd_a, 1); chk("R4", "fwd_b prio", fwd_b, 1);
    drain();
  endtask

  task automatic t_zero_and_nowrite();
    issue(0, 0, 0, 0, 0, 1, 0);
    issue(0, 0, 0, 0, 8, 0, 0);
    issue(0, 1, 8, 1, 9, 1, 0);
    nop();
    chk("R6", "fwd_a r0", fwd_a, 0); chk("R6", "fwd_b nowrite", fwd_b, 0);
    drain();
    issue(0, 0, 0, 0, 0, 1, 1);
    issue(0, 1, 0, 1, 4, 1, 0);
    chk("R6", "stall load r0", stall, 0);
    drain();
    issue(0, 0, 0, 0, 9, 1, 0);
    issue(9, 0, 9, 0, 4, 1, 0);
    nop();
    chk("R6", "fwd_a unused", fwd_a, 0); chk("R6", "fwd_b unused", fwd_b, 0);
    drain();
  endtask

  task automatic t_load_use();
    issue(0, 0, 0, 0, 9, 1, 1);
    issue(9, 1, 2, 1, 10, 1, 0);
    chk("R7", "stall load-use", stall, 1);
    issue(9, 1, 2, 1, 10, 1, 0);
    chk("R7", "stall released", stall, 0);
    chk("R7", "bubble fwd_a", fwd_a, 0);
    nop();
    chk("R7", "dependent fwd_a", fwd_a, 2); chk("R7", "dependent fwd_b", fwd_b, 0);
    drain();
    issue(0, 0, 0, 0, 12, 1, 1);
    issue(1, 1, 12, 1, 13, 1, 0);
    chk("R7", "stall rt", stall, 1);
    drain();
    issue(0, 0, 0, 0, 12, 1, 1);
    issue(1, 1, 12, 0, 13, 1, 0);
    chk("R6", "stall rt unused", stall, 0);
    drain();
  endtask

  task automatic t_load_indep();
    issue(0, 0, 0, 0, 11, 1, 1);
    issue(12, 1, 13, 1, 14, 1, 0);
    chk("R8", "stall indep", stall, 0);
    issue(11, 1, 0, 0, 15, 1, 0);
    chk("R8", "stall dist2", stall, 0);
    nop();
    chk("R8", "fwd_a dist2 load", fwd_a, 2);
    drain();
  endtask

  task automatic t_branch();
    issue(1, 1, 2, 1, 0, 0, 0, 1, 1);
    chk("R9", "flush taken", flush, 1); chk("R9", "stall taken", stall, 0);
    nop();
    chk("R9", "flush after", flush, 0);
    issue(1, 1, 2, 1, 0, 0, 0, 1, 0);
    chk("R9", "flush untaken", flush, 0);
    drain();
  endtask

  task automatic t_branch_load();
    issue(0, 0, 0, 0, 14, 1, 1);
    issue(14, 1, 3, 1, 0, 0, 0, 1, 1);
    chk("R10", "stall", stall, 1); chk("R10", "flush held", flush, 0);
    issue(14, 1, 3, 1, 0, 0, 0, 1, 1);
    chk("R10", "stall cleared", stall, 0); chk("R10", "flush late", flush, 1);
    drain();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_alu_chain();
    t_priority();
    t_zero_and_nowrite();
    t_load_use();
    t_load_indep();
    t_branch();
    t_branch_load();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule